// File: doc/BRIEF.md
# Register-Pair File with Dual Write

This block is a register file of sixteen 16-bit registers. It keeps the usual single-register path: two read ports addressed by register number and one write port. It also adds a double-width path for 32-bit arithmetic. A 2-bit pair code names one of four adjacent register pairs. Two such codes each read a full 32-bit operand at once. A third code, together with a pair write enable, stores a 32-bit result into both registers of a pair on one clock edge.

Pair codes map onto registers starting at R2 rather than R0. For code c, the low half sits in register 2c+2 and the high half in register 2c+3. The surrounding datapath uses this to feed a 32-bit adder or subtractor with four registers' worth of operands each cycle. It writes the sum back without a second write cycle. Register R0 is a hard zero. When a pair write and a single write arrive in the same cycle, the pair write wins.

There is no state machine here: the only state is the register array.

Top module: `regpair_file`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to zero, so all read ports return zero afterwards.
- R2: With `wr_en` high, `pair_wr_en` low and `wr_addr` nonzero, `wr_data` is stored in register `wr_addr` at the rising edge. The single read ports `rd_data_a`/`rd_data_b` return register `rd_addr_a`/`rd_addr_b` combinationally.
- R3: Register R0 always reads as zero, and a single write addressed to register 0 changes no register.
- R4: Pair code c (2 bits) selects low register 2c+2 and high register 2c+3: 00 gives R3:R2, 01 gives R5:R4, 10 gives R7:R6 and 11 gives R9:R8.
- R5: With `pair_wr_en` high, both registers of pair `pair_wr_sel` are updated on the same edge: `pair_wr_data[31:16]` goes to the odd (high) register and `pair_wr_data[15:0]` to the even (low) register.
- R6: The two pair read ports are independent and combinational. Each `pair_rd_x` equals {high register, low register} of its own code `pair_sel_x`.
- R7: When `pair_wr_en` and `wr_en` are both high, the single write is dropped whatever its address. Only the pair write takes effect.
- R8: A pair write leaves every register outside the selected pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-register write enable |
| wr_addr | input | 4 | Single write register number |
| wr_data | input | 16 | Single write data |
| rd_addr_a | input | 4 | Single read port A register number |
| rd_data_a | output | 16 | Single read port A data |
| rd_addr_b | input | 4 | Single read port B register number |
| rd_data_b | output | 16 | Single read port B data |
| pair_wr_en | input | 1 | Pair write enable (wins over `wr_en`) |
| pair_wr_sel | input | 2 | Destination pair code |
| pair_wr_data | input | 32 | Pair write data, {high, low} |
| pair_sel_a | input | 2 | Source pair code A |
| pair_rd_a | output | 32 | Pair operand A, {high, low} |
| pair_sel_b | input | 2 | Source pair code B |
| pair_rd_b | output | 32 | Pair operand B, {high, low} |

## Verification
The bound checker watches every cycle for these properties:
- the zero result after reset;
- R0 reading zero;
- a single write landing in its register;
- both halves of a pair write landing in the right registers;
- a losing single write leaving its target untouched.

The split of data across the two pair read ports, the exact code-to-register mapping, and untouched registers staying intact over long mixed sequences are shown only by the bench. It compares all read ports against its own model, over directed corner cases and seeded random traffic.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
    localparam int RPF_DATA_W   = 16;
    localparam int RPF_NUM_REGS = 16;
    localparam int RPF_SEL_W    = 2;
    localparam int RPF_BASE     = 2;
endpackage

// File: rtl/regpair_map.sv
// Converts a pair code into the register numbers of its low and high halves.
module regpair_map #(
    parameter int SEL_W = 2,
    parameter int IDX_W = 4,
    parameter int BASE  = 2
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx
);
    always_comb begin
        lo_idx = IDX_W'(BASE) + IDX_W'({sel, 1'b0});
        hi_idx = lo_idx + IDX_W'(1);
    end
endmodule

// File: rtl/regpair_wctl.sv
// Per-register write enable and data, with pair write priority.
module regpair_wctl #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                pair_wr_en,
    input  logic [IDX_W-1:0]    pw_lo_idx,
    input  logic [IDX_W-1:0]    pw_hi_idx,
    input  logic [2*DATA_W-1:0] pair_wr_data,
    output logic                reg_we [NUM_REGS],
    output logic [DATA_W-1:0]   reg_wd [NUM_REGS]
);
    assign reg_we[0] = 1'b0;
    assign reg_wd[0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        always_comb begin
            reg_we[i] = 1'b0;
            reg_wd[i] = wr_data;
            if (pair_wr_en) begin
                if (pw_lo_idx == IDX_W'(i)) begin
                    reg_we[i] = 1'b1;
                    reg_wd[i] = pair_wr_data[DATA_W-1:0];
                end else if (pw_hi_idx == IDX_W'(i)) begin
                    reg_we[i] = 1'b1;
                    reg_wd[i] = pair_wr_data[2*DATA_W-1:DATA_W];
                end
            end else if (wr_en && wr_addr == IDX_W'(i)) begin
                reg_we[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regpair_file.sv
module regpair_file
    import regpair_pkg::*;
#(
    parameter int DATA_W   = RPF_DATA_W,
    parameter int NUM_REGS = RPF_NUM_REGS,
    parameter int SEL_W    = RPF_SEL_W,
    parameter int BASE     = RPF_BASE,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PAIR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              pair_wr_en,
    input  logic [SEL_W-1:0]  pair_wr_sel,
    input  logic [PAIR_W-1:0] pair_wr_data,
    input  logic [SEL_W-1:0]  pair_sel_a,
    output logic [PAIR_W-1:0] pair_rd_a,
    input  logic [SEL_W-1:0]  pair_sel_b,
    output logic [PAIR_W-1:0] pair_rd_b
);
    logic [DATA_W-1:0] regs   [NUM_REGS];
    logic              reg_we [NUM_REGS];
    logic [DATA_W-1:0] reg_wd [NUM_REGS];

    logic [IDX_W-1:0] pw_lo, pw_hi, pa_lo, pa_hi, pb_lo, pb_hi;

    regpair_map #(.SEL_W(SEL_W), .IDX_W(IDX_W), .BASE(BASE)) u_map_w (
        .sel(pair_wr_sel), .lo_idx(pw_lo), .hi_idx(pw_hi));
    regpair_map #(.SEL_W(SEL_W), .IDX_W(IDX_W), .BASE(BASE)) u_map_a (
        .sel(pair_sel_a), .lo_idx(pa_lo), .hi_idx(pa_hi));
    regpair_map #(.SEL_W(SEL_W), .IDX_W(IDX_W), .BASE(BASE)) u_map_b (
        .sel(pair_sel_b), .lo_idx(pb_lo), .hi_idx(pb_hi));

    regpair_wctl #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wctl (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pair_wr_en(pair_wr_en), .pw_lo_idx(pw_lo), .pw_hi_idx(pw_hi),
        .pair_wr_data(pair_wr_data), .reg_we(reg_we), .reg_wd(reg_wd));

    // Storage; register 0 never has its enable raised, so it holds zero.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (reg_we[i]) begin
                regs[i] <= reg_wd[i];
            end
        end
    end

    always_comb begin
        rd_data_a = regs[rd_addr_a];
        rd_data_b = regs[rd_addr_b];
        pair_rd_a = {regs[pa_hi], regs[pa_lo]};
        pair_rd_b = {regs[pb_hi], regs[pb_lo]};
    end
endmodule

// File: rtl/regpair_checker.sv
module regpair_checker #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int SEL_W    = 2,
    parameter int BASE     = 2,
    parameter int IDX_W    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [IDX_W-1:0]    rd_addr_a,
    input logic [DATA_W-1:0]   rd_data_a,
    input logic                pair_wr_en,
    input logic [SEL_W-1:0]    pair_wr_sel,
    input logic [2*DATA_W-1:0] pair_wr_data,
    input logic [2*DATA_W-1:0] pair_rd_a,
    input logic [DATA_W-1:0]   regs [NUM_REGS]
);
    logic [IDX_W-1:0] exp_lo, exp_hi;
    assign exp_lo = IDX_W'(BASE + 2 * int'(pair_wr_sel));
    assign exp_hi = IDX_W'(BASE + 2 * int'(pair_wr_sel) + 1);

    // R1: reset leaves zero on the read ports.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rd_data_a == '0 && pair_rd_a == '0));

    // R3: register zero is a hard zero.
    a_r3_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    // R2: an uncontested single write lands in its register.
    a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pair_wr_en && wr_addr != '0)
        |=> regs[$past(wr_addr)] == $past(wr_data));

    // R5: both halves of a pair write land on the same edge.
    a_r5_pair_halves: assert property (@(posedge clk) disable iff (rst)
        pair_wr_en |=> (regs[$past(exp_lo)] == $past(pair_wr_data[DATA_W-1:0]) &&
                        regs[$past(exp_hi)] == $past(pair_wr_data[2*DATA_W-1:DATA_W])));

    // R7: a single write that loses to a pair write changes nothing.
    a_r7_pair_priority: assert property (@(posedge clk) disable iff (rst)
        (pair_wr_en && wr_en && wr_addr != exp_lo && wr_addr != exp_hi)
        |=> regs[$past(wr_addr)] == $past(regs[wr_addr]));
endmodule

bind regpair_file regpair_checker #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .BASE(BASE), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .pair_wr_en(pair_wr_en),
    .pair_wr_sel(pair_wr_sel), .pair_wr_data(pair_wr_data),
    .pair_rd_a(pair_rd_a), .regs(regs)
);

// File: tb/regpair_file_test.sv
module regpair_file_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  rd_addr_a, rd_addr_b;
    logic [15:0] rd_data_a, rd_data_b;
    logic        pair_wr_en;
    logic [1:0]  pair_wr_sel, pair_sel_a, pair_sel_b;
    logic [31:0] pair_wr_data, pair_rd_a, pair_rd_b;

    logic [15:0] model [16];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regpair_file uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .pair_wr_en(pair_wr_en), .pair_wr_sel(pair_wr_sel), .pair_wr_data(pair_wr_data),
        .pair_sel_a(pair_sel_a), .pair_rd_a(pair_rd_a),
        .pair_sel_b(pair_sel_b), .pair_rd_b(pair_rd_b)
    );

    function automatic int lo_of(input logic [1:0] c);
        return 2 * int'(c) + 2;
    endfunction

    function automatic logic [31:0] pair_exp(input logic [1:0] c);
        return {model[lo_of(c) + 1], model[lo_of(c)]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at edge, return at next negedge.
    task automatic cycle(input logic r, input logic we, input logic [3:0] wa,
                         input logic [15:0] wd, input logic pwe, input logic [1:0] ps,
                         input logic [31:0] pd);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        pair_wr_en = pwe; pair_wr_sel = ps; pair_wr_data = pd;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 16; i++) model[i] = '0;
        end else if (pwe) begin
            model[lo_of(ps)]     = pd[15:0];
            model[lo_of(ps) + 1] = pd[31:16];
        end else if (we && wa != 4'd0) begin
            model[wa] = wd;
        end
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; pair_wr_en = 1'b0;
    endtask

    task automatic check_reg(input string req, input int idx);
        rd_addr_a = 4'(idx); rd_addr_b = 4'(15 - idx);
        #1;
        check(req, {16'h0, rd_data_a}, {16'h0, model[idx]});
        check(req, {16'h0, rd_data_b}, {16'h0, model[15 - idx]});
    endtask

    task automatic check_pairs(input string req, input logic [1:0] a, input logic [1:0] b);
        pair_sel_a = a; pair_sel_b = b;
        #1;
        check(req, pair_rd_a, pair_exp(a));
        check(req, pair_rd_b, pair_exp(b));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
        pair_wr_en = 0; pair_wr_sel = 0; pair_wr_data = 0;
        rd_addr_a = 0; rd_addr_b = 0; pair_sel_a = 0; pair_sel_b = 0;
        for (int i = 0; i < 16; i++) model[i] = 'x;
        @(negedge clk);
        cycle(1, 0, 0, 0, 0, 0, 0);

        // R1: everything zero after reset
        for (int i = 0; i < 16; i++) check_reg("R1 reset", i);
        check_pairs("R1 reset pairs", 2'd0, 2'd3);

        // R2: single writes, including R1 and R15
        cycle(0, 1, 4'd1, 16'hA5A5, 0, 0, 0);
        cycle(0, 1, 4'd15, 16'h0F0F, 0, 0, 0);
        check_reg("R2 single write", 1);
        check_reg("R2 single write", 15);

        // R3: write to register 0 ignored
        cycle(0, 1, 4'd0, 16'hFFFF, 0, 0, 0);
        check_reg("R3 zero register", 0);

        // R4/R5: a pair write per code, distinct halves
        for (int c = 0; c < 4; c++)
            cycle(0, 0, 0, 0, 1, 2'(c), {16'h1000 + 16'(c), 16'h2000 + 16'(c)});
        for (int c = 0; c < 4; c++) begin
            check_reg("R4 pair map low", 2 * c + 2);
            check_reg("R5 pair high half", 2 * c + 3);
        end
        // R6: both pair ports at once, different codes
        check_pairs("R6 dual pair read", 2'd0, 2'd3);
        check_pairs("R6 dual pair read", 2'd2, 2'd1);

        // R5: carry-style result crossing into the high half
        cycle(0, 0, 0, 0, 1, 2'd1, 32'h0001_F402);
        check_pairs("R5 wide result", 2'd1, 2'd1);

        // R7: contested write, single address outside the pair
        cycle(0, 1, 4'd12, 16'hDEAD, 1, 2'd2, 32'hCAFE_BEEF);
        check_reg("R7 priority other reg", 12);
        check_pairs("R7 pair applied", 2'd2, 2'd0);
        // R7: contested write, single address inside the pair
        cycle(0, 1, 4'd8, 16'h7777, 1, 2'd3, 32'h1111_2222);
        check_reg("R7 priority same reg", 8);

        // R8: registers outside the pair are untouched
        cycle(0, 0, 0, 0, 1, 2'd0, 32'h5555_6666);
        for (int i = 0; i < 16; i++) check_reg("R8 others kept", i);

        // Random traffic against the model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[31:28] == 4'd0, r[0], 4'($urandom), 16'($urandom),
                  r[1] & r[2], 2'($urandom), $urandom);
            check_reg("R2 random", int'(r[11:8]));
            check_pairs("R6 random", r[13:12], r[15:14]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule